// File: doc/BRIEF.md
# Integer-N Synthesizer Digital Core

This block holds the digital half of an integer-N frequency synthesizer. A fixed divider turns the crystal clock into a comparison reference. A programmable divider scales the oscillator clock by an 11-bit ratio. A phase/frequency detector then compares the falling edges of the two divided signals. It drives two pulse outputs, source and sink, toward an external charge pump. The charge pump, loop filter and oscillator sit outside the block.

A one-bit pump-strength select is registered in the crystal domain and passed to the pump. It chooses between the low setting (one unit of current) and the high setting (five units), so the loop can be tuned differently while acquiring and once settled. A lock flag rises after a run of consecutive comparisons in which the one-sided pulse stays short. The two divided signals are also brought out as test points.

Top module: `pll_synth_core`

## Requirements
- R1: `ref_clk_o` has a period of exactly REF_DIV (default 200) crystal clock cycles. It is high for REF_DIV/2 of them and falls on the crystal edge that starts a new period.
- R2: `fb_clk_o` has a period of exactly N oscillator cycles, where N is the value on `n_ratio_i`, for any N from 1024 to 2047. It falls on the oscillator edge that starts a new period.
- R3: A ratio below 1024 on `n_ratio_i` divides by 1024.
- R4: A new ratio is taken only when the divider wraps. A change made in mid-period leaves that period at the old length, and the following period uses the new one.
- R5: When `fb_clk_o` falls before `ref_clk_o`, `up_o` is high alone from the `fb_clk_o` fall until the `ref_clk_o` fall.
- R6: When `ref_clk_o` falls before `fb_clk_o`, `dn_o` is high alone from the `ref_clk_o` fall until the `fb_clk_o` fall.
- R7: When the two falling edges coincide, neither output is high alone. In every comparison, the interval with both outputs high ends within two crystal cycles, after which both outputs are low.
- R8: `gain_o` equals the value `hi_gain_i` had at the previous rising crystal edge. 1 selects five-unit pump current and 0 selects one unit.
- R9: `lock_o` rises after LOCK_CNT (default 8) consecutive comparisons. In each of them, fewer than LOCK_THR (default 4) crystal edges sampled exactly one of `up_o`/`dn_o` high. `lock_o` is never high after fewer comparisons.
- R10: `lock_o` falls one crystal edge after the one-sided pulse of a comparison reaches LOCK_THR crystal edges.
- R11: While `rst_ni` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| xtal_clk_i | input | 1 | Crystal clock |
| vco_clk_i | input | 1 | Oscillator clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| n_ratio_i | input | 11 | Oscillator division ratio |
| hi_gain_i | input | 1 | Pump-strength request (1 = five units) |
| up_o | output | 1 | Source pulse to the charge pump |
| dn_o | output | 1 | Sink pulse to the charge pump |
| gain_o | output | 1 | Registered pump-strength select |
| lock_o | output | 1 | Loop lock flag |
| ref_clk_o | output | 1 | Divided reference test point |
| fb_clk_o | output | 1 | Divided oscillator test point |

## Verification
The bench aligns both clocks so that the divided edges fall in the same instant. A detector that lets one flop win would then leave a sliver of one-sided pulse and spoil lock. Slow phase drift in each direction measures the exclusive pulse time against edge timestamps on every comparison. Those runs would catch swapped source/sink wiring, a clear path that eats an edge, or a lock flag that never drops once the error grows. Ratio tests cover random values, values under the floor (a missing clamp would give short periods), and a change in mid-period (loading early would shorten the running period). The lock flag is sampled after seven and after ten aligned comparisons, which catches an off-by-one in the qualifying count.

// File: rtl/pll_pkg.sv
`timescale 1ns/1ps
package pll_pkg;
  // {up, dn} view of the detector
  typedef enum logic [1:0] {
    PD_IDLE = 2'b00,
    PD_DN   = 2'b01,
    PD_UP   = 2'b10,
    PD_BOTH = 2'b11
  } pd_state_e;
endpackage

// File: rtl/pll_div.sv
`timescale 1ns/1ps
module pll_div #(
  parameter int unsigned W         = 11,
  parameter int unsigned MIN_RATIO = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ratio_i,
  output logic         div_o
);
  localparam logic [W-1:0] MinR = W'(MIN_RATIO);

  logic [W-1:0] cnt_q, cnt_d, ratio_q, ratio_d;
  logic         div_q, div_d, wrap;

  // down-counter; ratio sampled only at wrap, output falls at wrap
  always_comb begin
    wrap    = (cnt_q == '0);
    ratio_d = ratio_q;
    cnt_d   = cnt_q - W'(1);
    if (wrap) begin
      ratio_d = (ratio_i < MinR) ? MinR : ratio_i;
      cnt_d   = ratio_d - W'(1);
    end
    div_d = (cnt_d < (ratio_d >> 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= MinR;
      div_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      div_q   <= div_d;
    end
  end

  assign div_o = div_q;

  p_cnt_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_q);
  p_ratio_floor_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_q >= MinR);
endmodule

// File: rtl/pll_pfd.sv
`timescale 1ns/1ps
module pll_pfd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  input  logic fb_i,
  output logic up_o,
  output logic dn_o,
  output logic done_o
);
  logic up_q, dn_q, clr_q, clr_n;

  assign clr_n = rst_ni & ~clr_q;

  always_ff @(negedge fb_i or negedge clr_n) begin
    if (!clr_n) up_q <= 1'b0;
    else        up_q <= 1'b1;
  end

  always_ff @(negedge ref_i or negedge clr_n) begin
    if (!clr_n) dn_q <= 1'b0;
    else        dn_q <= 1'b1;
  end

  // both fired: clear for one crystal cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_q <= 1'b0;
    else         clr_q <= up_q & dn_q & ~clr_q;
  end

  assign up_o   = up_q;
  assign dn_o   = dn_q;
  assign done_o = clr_q;

  p_clear_empties_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |-> !(up_q || dn_q));
endmodule

// File: rtl/pll_lock.sv
`timescale 1ns/1ps
module pll_lock
  import pll_pkg::*;
#(
  parameter int unsigned LOCK_CNT = 8,
  parameter int unsigned LOCK_THR = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic up_i,
  input  logic dn_i,
  input  logic done_i,
  output logic lock_o
);
  localparam int unsigned WW = $clog2(LOCK_THR + 1);
  localparam int unsigned GW = $clog2(LOCK_CNT + 1);
  localparam logic [WW-1:0] Thr  = WW'(LOCK_THR);
  localparam logic [GW-1:0] Need = GW'(LOCK_CNT);

  pd_state_e    st;
  logic         one_sided;
  logic [WW-1:0] wid_q;
  logic [GW-1:0] good_q;

  assign st        = pd_state_e'({up_i, dn_i});
  assign one_sided = (st == PD_UP) || (st == PD_DN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wid_q <= '0;
    end else if (done_i) begin
      wid_q <= '0;
    end else if (one_sided && (wid_q != Thr)) begin
      wid_q <= wid_q + WW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_q <= '0;
    end else if (wid_q == Thr) begin
      good_q <= '0;
    end else if (done_i && (good_q != Need)) begin
      good_q <= good_q + GW'(1);
    end
  end

  assign lock_o = (good_q == Need);

  p_lock_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wid_q == Thr) |=> !lock_o);
  p_lock_on_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(done_i));
endmodule

// File: rtl/pll_synth_core.sv
`timescale 1ns/1ps
module pll_synth_core #(
  parameter int unsigned REF_DIV  = 200,
  parameter int unsigned N_W      = 11,
  parameter int unsigned LOCK_CNT = 8,
  parameter int unsigned LOCK_THR = 4
) (
  input  logic           xtal_clk_i,
  input  logic           vco_clk_i,
  input  logic           rst_ni,
  input  logic [N_W-1:0] n_ratio_i,
  input  logic           hi_gain_i,
  output logic           up_o,
  output logic           dn_o,
  output logic           gain_o,
  output logic           lock_o,
  output logic           ref_clk_o,
  output logic           fb_clk_o
);
  localparam int unsigned REF_W = $clog2(REF_DIV + 1);
  localparam int unsigned N_MIN = 1 << (N_W - 1);

  logic ref_div, fb_div, cmp_done, gain_q;

  pll_div #(.W(REF_W), .MIN_RATIO(REF_DIV)) i_ref_div (
    .clk_i  (xtal_clk_i),
    .rst_ni (rst_ni),
    .ratio_i(REF_W'(REF_DIV)),
    .div_o  (ref_div)
  );

  pll_div #(.W(N_W), .MIN_RATIO(N_MIN)) i_fb_div (
    .clk_i  (vco_clk_i),
    .rst_ni (rst_ni),
    .ratio_i(n_ratio_i),
    .div_o  (fb_div)
  );

  pll_pfd i_pfd (
    .clk_i (xtal_clk_i),
    .rst_ni(rst_ni),
    .ref_i (ref_div),
    .fb_i  (fb_div),
    .up_o  (up_o),
    .dn_o  (dn_o),
    .done_o(cmp_done)
  );

  pll_lock #(.LOCK_CNT(LOCK_CNT), .LOCK_THR(LOCK_THR)) i_lock (
    .clk_i (xtal_clk_i),
    .rst_ni(rst_ni),
    .up_i  (up_o),
    .dn_i  (dn_o),
    .done_i(cmp_done),
    .lock_o(lock_o)
  );

  always_ff @(posedge xtal_clk_i or negedge rst_ni) begin
    if (!rst_ni) gain_q <= 1'b0;
    else         gain_q <= hi_gain_i;
  end

  assign gain_o    = gain_q;
  assign ref_clk_o = ref_div;
  assign fb_clk_o  = fb_div;

  p_gain_follow_r8: assert property (@(posedge xtal_clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (gain_o == $past(hi_gain_i)));
endmodule

// File: tb/test_pll_synth_core.sv
`timescale 1ns/1ps
module test_pll_synth_core;
  localparam int REF_DIV  = 200;
  localparam int LOCK_CNT = 8;

  logic        xtal = 1'b0;
  logic        vco  = 1'b1;
  logic        rst_n = 1'b0;
  logic [10:0] n_i = 11'd2000;
  logic        hi_gain = 1'b0;
  logic up_o, dn_o, gain_o, lock_o, ref_clk_o, fb_clk_o;

  real vhalf = 1.0;
  int  n_vec = 0;
  int  n_err = 0;

  pll_synth_core i_pll_synth_core (
    .xtal_clk_i(xtal), .vco_clk_i(vco), .rst_ni(rst_n),
    .n_ratio_i(n_i), .hi_gain_i(hi_gain),
    .up_o(up_o), .dn_o(dn_o), .gain_o(gain_o), .lock_o(lock_o),
    .ref_clk_o(ref_clk_o), .fb_clk_o(fb_clk_o)
  );

  always #10 xtal = ~xtal;
  initial forever #(vhalf) vco = ~vco;

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
  endtask

  task automatic check_int(input string tag, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_real(input string tag, input real act, input real exp, input real tol);
    n_vec++;
    if (act > exp + tol || act < exp - tol) begin
      n_err++;
      $display("FAIL %s: actual=%0.3f expected=%0.3f", tag, act, exp);
    end
  endtask

  // ---------------- detector monitor ----------------
  bit  mon_en = 1'b0;
  bit  got_fb, got_ref, pu, pd;
  real t_fb, t_ref, t_last, acc_up, acc_dn, acc_both, dt, exp_up, exp_dn;
  int  cmp_cnt = 0;

  task automatic mon_reset();
    got_fb = 0; got_ref = 0; pu = 0; pd = 0;
    acc_up = 0.0; acc_dn = 0.0; acc_both = 0.0;
    t_last = $realtime; cmp_cnt = 0;
  endtask

  always @(negedge fb_clk_o)  if (mon_en) begin t_fb  = $realtime; got_fb  = 1; end
  always @(negedge ref_clk_o) if (mon_en) begin t_ref = $realtime; got_ref = 1; end

  always @(up_o or dn_o) begin
    if (mon_en) begin
      dt = $realtime - t_last;
      if (pu && !pd)      acc_up   += dt;
      else if (!pu && pd) acc_dn   += dt;
      else if (pu && pd)  acc_both += dt;
      t_last = $realtime;
      if (pu && pd && !up_o && !dn_o) begin
        check_int("R7 both edges seen before clear", int'(got_fb && got_ref), 1);
        exp_up = (t_ref > t_fb) ? t_ref - t_fb : 0.0;
        exp_dn = (t_fb > t_ref) ? t_fb - t_ref : 0.0;
        if (exp_up > 0.0)      check_real("R5 up-only time", acc_up, exp_up, 0.05);
        else if (exp_dn > 0.0) check_real("R5 up-only time (dn case)", acc_up, 0.0, 0.05);
        else                   check_real("R7 coincident up-only time", acc_up, 0.0, 0.05);
        if (exp_dn > 0.0)      check_real("R6 dn-only time", acc_dn, exp_dn, 0.05);
        else if (exp_up > 0.0) check_real("R6 dn-only time (up case)", acc_dn, 0.0, 0.05);
        else                   check_real("R7 coincident dn-only time", acc_dn, 0.0, 0.05);
        n_vec++;
        if (acc_both > 40.05) begin
          n_err++;
          $display("FAIL R7 overlap: actual=%0.3f expected<=40.000", acc_both);
        end
        acc_up = 0.0; acc_dn = 0.0; acc_both = 0.0;
        got_fb = 0; got_ref = 0;
        cmp_cnt++;
      end
      pu = up_o; pd = dn_o;
    end
  end

  // ---------------- helpers ----------------
  task automatic do_reset();
    mon_en = 0;
    @(negedge xtal); rst_n = 1'b0;
    repeat (4) @(negedge xtal);
    check_int("R11 up_o in reset", up_o, 0);
    check_int("R11 dn_o in reset", dn_o, 0);
    check_int("R11 lock_o in reset", lock_o, 0);
    check_int("R11 gain_o in reset", gain_o, 0);
    check_int("R11 ref_clk_o in reset", ref_clk_o, 0);
    check_int("R11 fb_clk_o in reset", fb_clk_o, 0);
    @(negedge xtal); #9;
    rst_n = 1'b1;
    mon_reset();
    mon_en = 1;
  endtask

  task automatic sync_fb();
    bit prev;
    prev = fb_clk_o;
    while (1) begin
      @(posedge vco); #0.3;
      if (prev && !fb_clk_o) break;
      prev = fb_clk_o;
    end
  endtask

  // count oscillator edges to the next fb fall; optional ratio change on the way
  task automatic fb_period(input int chg_at, input logic [10:0] new_n, output int c);
    bit prev;
    c = 0; prev = fb_clk_o;
    while (1) begin
      @(posedge vco); #0.3;
      c++;
      if (c == chg_at) n_i = new_n;
      if (prev && !fb_clk_o) break;
      prev = fb_clk_o;
    end
  endtask

  task automatic ref_period(output int per, output int hi);
    bit prev;
    prev = ref_clk_o;
    while (1) begin
      @(posedge xtal); #1;
      if (prev && !ref_clk_o) break;
      prev = ref_clk_o;
    end
    per = 0; hi = 0; prev = ref_clk_o;
    while (1) begin
      @(posedge xtal); #1;
      per++;
      if (ref_clk_o) hi++;
      if (prev && !ref_clk_o) break;
      prev = ref_clk_o;
    end
  endtask

  function automatic int clamp_n(input int n);
    return (n < 1024) ? 1024 : n;
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge xtal);
    n_vec++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    int per, hi, c, c1, c2, nv;
    bit g;
    void'($urandom(32'd1357));

    // aligned clocks: divided edges coincide (N=2000, 2 ns oscillator)
    n_i = 11'd2000; vhalf = 1.0; hi_gain = 1'b1;
    do_reset();
    wait (cmp_cnt >= LOCK_CNT - 1);
    repeat (50) @(negedge xtal);
    check_int("R9 lock low after 7 comparisons", lock_o, 0);
    wait (cmp_cnt >= LOCK_CNT + 2);
    repeat (50) @(negedge xtal);
    check_int("R9 lock high after 10 aligned comparisons", lock_o, 1);

    for (int i = 0; i < 10; i++) begin
      g = 1'($urandom_range(1));
      @(negedge xtal); hi_gain = g;
      @(negedge xtal);
      check_int("R8 gain follows select", gain_o, g);
    end

    ref_period(per, hi);
    check_int("R1 reference period", per, REF_DIV);
    check_int("R1 reference high time", hi, REF_DIV / 2);
    ref_period(per, hi);
    check_int("R1 reference period again", per, REF_DIV);

    // ratio tests, detector monitor off
    mon_en = 0;
    vhalf = 1.6;
    for (int i = 0; i < 6; i++) begin
      nv = 1024 + int'($urandom_range(1023));
      if (i == 0) nv = 1024;
      if (i == 1) nv = 2047;
      n_i = 11'(nv);
      sync_fb();
      fb_period(0, 11'd0, c);
      check_int("R2 divide period", c, nv);
    end
    for (int i = 0; i < 4; i++) begin
      nv = int'($urandom_range(1023));
      if (i == 0) nv = 1023;
      if (i == 1) nv = 0;
      n_i = 11'(nv);
      sync_fb();
      fb_period(0, 11'd0, c);
      check_int("R3 clamped period", c, clamp_n(nv));
    end
    n_i = 11'd1500;
    sync_fb();
    fb_period(0, 11'd0, c);
    check_int("R2 settle period", c, 1500);
    fb_period(200, 11'd1100, c1);
    check_int("R4 running period keeps old ratio", c1, 1500);
    fb_period(0, 11'd0, c2);
    check_int("R4 next period takes new ratio", c2, 1100);

    // oscillator slightly fast: up pulses grow until lock is lost
    n_i = 11'd1250; vhalf = 1.597;
    do_reset();
    wait (cmp_cnt >= 20);
    repeat (50) @(negedge xtal);
    check_int("R10 lock lost under growing up error", lock_o, 0);

    // oscillator slightly slow: dn pulses grow
    vhalf = 1.603;
    do_reset();
    wait (cmp_cnt >= 20);
    repeat (50) @(negedge xtal);
    check_int("R10 lock lost under growing dn error", lock_o, 0);

    mon_en = 0;
    report();
    $finish;
  end
endmodule